// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge. Software reaches it one byte at a time. A cycle with the write strobe high stores a byte at the given offset. Every cycle the block also returns the byte at the presented offset, one clock later. Each offset has its own write mask, so reserved bits stay at zero. The four identification bytes at the bottom of the space are fixed at reset and cannot be written.

A few registers also act on the rest of the chip. One bit drives the external-cache enable level. A write to any shadow-control byte, or to either SMRAM-control byte, raises a single-cycle recalculation strobe, and the logic that owns that mapping then re-reads the space. The SMI control byte works as a trigger. Writing it with the trigger bit set fires a registered single-cycle SMI request, but only when the enable bit in a separate enable register is already set. The same write also wipes the upper seven bits of a companion status byte, whether or not the request fires.

Top module: `hbcfg_regfile`

## Requirements
- R1: After reset, offsets 0x00..0x03 read 0x5A, 0x1C, 0x42, 0x07 (vendor identifier low/high byte, then device identifier low/high byte). Every other offset reads 0x00, and `cache_en`, `shadow_upd`, `smram_upd` and `smi_req` are low.
- R2: Writes to offsets 0x00..0x03 have no effect: those bytes keep their reset values.
- R3: A write to offset 0x04 stores the written byte ANDed with 0xCF, so bits 5:4 always read zero.
- R4: Offsets 0x07 and 0x5F store the written byte ANDed with 0xFE, and offset 0x66 stores it ANDed with 0x7F.
- R5: Any other offset stores the full written byte. `rdata` shows the byte at `addr` one clock edge after the address is presented.
- R6: `cache_en` equals bit 6 of offset 0x51 and follows a write to that offset in the same clock edge that stores it.
- R7: A write to an offset from 0x53 to 0x56 makes `shadow_upd` high for exactly the one cycle after the write edge. Writes to other offsets leave it low.
- R8: A write to offset 0x64 or 0x65 makes `smram_upd` high for exactly the one cycle after the write edge. Writes to other offsets leave it low.
- R9: A write to offset 0x60 with bit 1 set, while bit 0 of offset 0x68 is set, makes `smi_req` high for exactly the one cycle after the write edge.
- R10: `smi_req` stays low for a write to 0x60 with bit 1 clear, for a write to 0x60 with bit 1 set while bit 0 of 0x68 is clear, and for writes to any other offset.
- R11: A write to 0x60 with bit 1 set leaves offset 0x69 holding only its previous bit 0, whatever the state of 0x68. A write to 0x60 with bit 1 clear leaves 0x69 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 8 | Byte offset for the write and for the read |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Stored byte at the offset presented on the previous cycle |
| cache_en | output | 1 | External-cache enable level |
| shadow_upd | output | 1 | One-cycle shadow-map recalculation strobe |
| smram_upd | output | 1 | One-cycle SMRAM recalculation strobe |
| smi_req | output | 1 | One-cycle registered SMI request |

## Verification
The hardest case is the interaction between the SMI trigger, its enable register and the status byte. The request and the status wipe depend on a value written earlier to a different offset, and the status wipe has no visible output of its own. The stimulus first loads 0x69 with a pattern whose upper bits are all non-zero. It then fires the trigger with the enable clear, with it set, and with the trigger bit clear, and reads 0x69 back after each case. This separates the wipe from the request gating and from the no-trigger case.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREGS  = 1 << ADDR_W;
  localparam int unsigned ID_BYTES = 4;

  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_STAT    = 8'h07;
  localparam logic [7:0] OFS_CACHE   = 8'h51;
  localparam logic [7:0] OFS_SHD_LO  = 8'h53;
  localparam logic [7:0] OFS_SHD_HI  = 8'h56;
  localparam logic [7:0] OFS_RSV_A   = 8'h5F;
  localparam logic [7:0] OFS_SMI_CTL = 8'h60;
  localparam logic [7:0] OFS_SMR_A   = 8'h64;
  localparam logic [7:0] OFS_SMR_B   = 8'h65;
  localparam logic [7:0] OFS_RSV_B   = 8'h66;
  localparam logic [7:0] OFS_SMI_EN  = 8'h68;
  localparam logic [7:0] OFS_SMI_STS = 8'h69;

  localparam int unsigned CACHE_BIT = 6;
  localparam int unsigned TRIG_BIT  = 1;
  localparam int unsigned EN_BIT    = 0;
  localparam logic [7:0]  STS_KEEP  = 8'h01;

  typedef struct packed {
    logic shadow;
    logic smram;
    logic smi_try;
  } evt_t;

  // Per-offset write mask: a set bit may be written.
  function automatic logic [7:0] wmask_of(input logic [7:0] a);
    logic [7:0] m;
    unique case (a)
      OFS_CMD:              m = 8'hCF;
      OFS_STAT, OFS_RSV_A:  m = 8'hFE;
      OFS_RSV_B:            m = 8'h7F;
      default:              m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic is_id(input logic [7:0] a);
    return a < 8'(ID_BYTES);
  endfunction

  function automatic logic is_shadow(input logic [7:0] a);
    return (a >= OFS_SHD_LO) && (a <= OFS_SHD_HI);
  endfunction

  function automatic logic is_smram(input logic [7:0] a);
    return (a == OFS_SMR_A) || (a == OFS_SMR_B);
  endfunction

  // Reset image of the identification bytes, little-endian.
  function automatic logic [7:0] id_byte(input int idx,
                                         input logic [15:0] ven,
                                         input logic [15:0] dev);
    logic [31:0] word;
    word = {dev, ven};
    return word[idx*8 +: 8];
  endfunction

endpackage

// File: rtl/hbcfg_decode.sv
module hbcfg_decode
  import hbcfg_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       wr_fire,
  output logic [7:0] wdata_m,
  output logic       clr_sts,
  output evt_t       evt
);

  // Writes into the identification window are dropped here.
  assign wr_fire = wr_en && !is_id(addr);
  assign wdata_m = wdata & wmask_of(addr);

  always_comb begin
    evt.shadow  = wr_fire && is_shadow(addr);
    evt.smram   = wr_fire && is_smram(addr);
    evt.smi_try = wr_fire && (addr == OFS_SMI_CTL) && wdata[TRIG_BIT];
  end

  assign clr_sts = evt.smi_try;

endmodule

// File: rtl/hbcfg_store.sv
module hbcfg_store
  import hbcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1C5A,
  parameter logic [15:0] DEVICE_ID = 16'h0742
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic [7:0] addr,
  input  logic [7:0] wdata_m,
  input  logic       clr_sts,
  output logic [7:0] rdata,
  output logic       cache_bit,
  output logic       smi_en
);

  logic [7:0] regs [NREGS];

  for (genvar g = 0; g < int'(NREGS); g++) begin : g_byte
    if (g < int'(ID_BYTES)) begin : g_id
      assign regs[g] = id_byte(g, VENDOR_ID, DEVICE_ID);
    end else if (g == int'(OFS_SMI_STS)) begin : g_sts
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                           byte_q <= '0;
        else if (wr_fire && addr == 8'(g))    byte_q <= wdata_m;
        else if (clr_sts)                     byte_q <= byte_q & STS_KEEP;
      end
      assign regs[g] = byte_q;
    end else begin : g_rw
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                           byte_q <= '0;
        else if (wr_fire && addr == 8'(g))    byte_q <= wdata_m;
      end
      assign regs[g] = byte_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= regs[addr];
  end

  assign cache_bit = regs[OFS_CACHE][CACHE_BIT];
  assign smi_en    = regs[OFS_SMI_EN][EN_BIT];

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable({regs[0], regs[1], regs[2], regs[3]})); // R2
  AST_CMD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[OFS_CMD] & 8'h30) == 8'h00); // R3
  AST_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[OFS_STAT][0] && !regs[OFS_RSV_A][0]); // R4
  AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[OFS_RSV_B][7]); // R4
  AST_STS_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sts |=> (regs[OFS_SMI_STS] & 8'hFE) == 8'h00); // R11

endmodule

// File: rtl/hbcfg_events.sv
module hbcfg_events
  import hbcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t evt,
  input  logic smi_en,
  output logic shadow_upd,
  output logic smram_upd,
  output logic smi_req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_upd <= 1'b0;
      smram_upd  <= 1'b0;
      smi_req    <= 1'b0;
    end else begin
      shadow_upd <= evt.shadow;
      smram_upd  <= evt.smram;
      smi_req    <= evt.smi_try && smi_en;
    end
  end

  AST_SHADOW_STB: assert property (@(posedge clk) disable iff (!rst_n)
    evt.shadow |=> shadow_upd); // R7
  AST_SMRAM_STB: assert property (@(posedge clk) disable iff (!rst_n)
    evt.smram |=> smram_upd); // R8
  AST_SMI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(smi_en)); // R9
  AST_SMI_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.smi_try |=> !smi_req); // R10

endmodule

// File: rtl/hbcfg_regfile.sv
module hbcfg_regfile
  import hbcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1C5A,
  parameter logic [15:0] DEVICE_ID = 16'h0742
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       cache_en,
  output logic       shadow_upd,
  output logic       smram_upd,
  output logic       smi_req
);

  logic       wr_fire;
  logic [7:0] wdata_m;
  logic       clr_sts;
  evt_t       evt;
  logic       cache_bit;
  logic       smi_en;

  hbcfg_decode u_decode (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .wr_fire (wr_fire),
    .wdata_m (wdata_m),
    .clr_sts (clr_sts),
    .evt     (evt)
  );

  hbcfg_store #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .addr      (addr),
    .wdata_m   (wdata_m),
    .clr_sts   (clr_sts),
    .rdata     (rdata),
    .cache_bit (cache_bit),
    .smi_en    (smi_en)
  );

  hbcfg_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .smi_en     (smi_en),
    .shadow_upd (shadow_upd),
    .smram_upd  (smram_upd),
    .smi_req    (smi_req)
  );

  assign cache_en = cache_bit;

  AST_CACHE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CACHE) |=> cache_en == $past(wdata[CACHE_BIT])); // R6

endmodule

// File: tb/hbcfg_regfile_tb.sv
module hbcfg_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr  = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cache_en, shadow_upd, smram_upd, smi_req;

  hbcfg_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cache_en(cache_en), .shadow_upd(shadow_upd),
    .smram_upd(smram_upd), .smi_req(smi_req)
  );

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [7:0] model [256];

  typedef struct {
    logic [7:0] exp;
    logic [7:0] a;
    string      tag;
  } item_t;
  item_t sb_q[$];
  logic issue = 1'b0;
  logic pend_q = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Stored value a write is expected to leave, per the requirements.
  function automatic logic [7:0] keep_bits(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h04) return {d[7:6], 2'b00, d[3:0]};
    if (a == 8'h07 || a == 8'h5F) return {d[7:1], 1'b0};
    if (a == 8'h66) return {1'b0, d[6:0]};
    return d;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic e_sh, e_sm, e_smi;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    e_sh  = (a inside {8'h53, 8'h54, 8'h55, 8'h56});
    e_sm  = (a inside {8'h64, 8'h65});
    e_smi = (a == 8'h60) && d[1] && model[8'h68][0];
    if (a > 8'h03) model[a] = keep_bits(a, d);
    if (a == 8'h60 && d[1]) model[8'h69] = {7'b0, model[8'h69][0]};
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 shadow strobe", {7'b0, shadow_upd}, {7'b0, e_sh});
    chk("R8 smram strobe", {7'b0, smram_upd}, {7'b0, e_sm});
    chk("R9 R10 smi pulse", {7'b0, smi_req}, {7'b0, e_smi});
    chk("R6 cache enable", {7'b0, cache_en}, {7'b0, model[8'h51][6]});
  endtask

  task automatic idle_quiet(input string tag);
    @(negedge clk);
    chk(tag, {5'b0, shadow_upd, smram_upd, smi_req}, 8'h00);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a; issue = 1'b1;
    it.exp = model[a]; it.a = a; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    issue = 1'b0;
  endtask

  // Monitor: a read issued last cycle is due at this falling edge.
  always @(posedge clk) pend_q <= issue;
  always @(negedge clk) begin
    if (pend_q) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 scoreboard empty actual %02h expected none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk($sformatf("%s @%02h", it.tag, it.a), rdata, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[0] = 8'h5A; model[1] = 8'h1C; model[2] = 8'h42; model[3] = 8'h07;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs low and whole space at reset image
    chk("R1 outputs after reset", {4'b0, cache_en, shadow_upd, smram_upd, smi_req}, 8'h00);
    for (int i = 0; i < 256; i++) rd(8'(i), "R1 reset image");

    // R2: identification bytes ignore writes
    for (int i = 0; i < 4; i++) wr(8'(i), 8'hFF);
    for (int i = 0; i < 4; i++) rd(8'(i), "R2 id locked");

    // R3 / R4: masked offsets
    wr(8'h04, 8'hFF); rd(8'h04, "R3 command mask");
    wr(8'h04, 8'h35); rd(8'h04, "R3 command mask");
    wr(8'h07, 8'hFF); rd(8'h07, "R4 status mask");
    wr(8'h5F, 8'h81); rd(8'h5F, "R4 5F mask");
    wr(8'h66, 8'hFF); rd(8'h66, "R4 66 mask");

    // R5: plain offsets, several patterns
    wr(8'h10, 8'hA5); wr(8'h80, 8'h3C); wr(8'hFF, 8'h5A); wr(8'h04 + 8'h01, 8'hC3);
    rd(8'h10, "R5 plain"); rd(8'h80, "R5 plain"); rd(8'hFF, "R5 plain"); rd(8'h05, "R5 plain");

    // R6: cache enable
    wr(8'h51, 8'h40); wr(8'h51, 8'hBF); wr(8'h51, 8'hC0);
    rd(8'h51, "R6 cache byte");

    // R7: shadow strobes, back to back and neighbours
    wr(8'h52, 8'h11); wr(8'h53, 8'h01); wr(8'h54, 8'h02); wr(8'h55, 8'h03);
    wr(8'h56, 8'h04); idle_quiet("R7 strobe drops"); wr(8'h57, 8'h05);

    // R8: SMRAM strobes
    wr(8'h63, 8'h01); wr(8'h64, 8'h10); idle_quiet("R8 strobe drops");
    wr(8'h65, 8'h20); wr(8'h66, 8'h01);

    // R9 / R10 / R11: SMI trigger, enable and status wipe
    wr(8'h69, 8'hFF); wr(8'h68, 8'h00);
    wr(8'h60, 8'h02);                       // trigger without enable
    rd(8'h69, "R11 wipe without enable");
    wr(8'h69, 8'hAB); wr(8'h68, 8'h01);
    wr(8'h60, 8'h02);                       // enabled trigger
    idle_quiet("R9 smi single cycle");
    rd(8'h69, "R11 wipe keeps bit0");
    wr(8'h69, 8'hAA);
    wr(8'h60, 8'hFD);                       // trigger bit clear
    rd(8'h69, "R11 untouched without trigger");
    rd(8'h60, "R5 smi control stored");
    wr(8'h60, 8'hFF); wr(8'h60, 8'h02);     // back-to-back pulses
    rd(8'h69, "R11 wipe again");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R5 pending reads actual %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule